// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

The block is a clocked lock controller. A user enters a secret code of three 4-bit digits one at a time on a shared data bus, and each digit is marked valid by a single-cycle entry strobe. Three code registers hold the secret. A one-hot selector, driven straight from the controller's state flops, picks the digit that is expected next. A combinational equality compare judges the entry against that digit.

A correct entry moves the controller to the next digit. After the third correct digit the lock opens. A wrong digit sends the controller to an error state. The open and error states are both terminal, and only a synchronous reset leaves them. Reset returns the controller to the first digit and restores the default code 3, 4, 2.

The code registers are written from the same data bus through three independent write enables. One enable or several may be raised together, so the secret can be changed while an entry is in progress.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to the first-digit state: `digit_sel` = 001 and `unlocked` = 0. The code registers return to the defaults, digit 1 = 3, digit 2 = 4 and digit 3 = 2.
- R2: In a digit-checking state, an edge with `entry_stb` low leaves `digit_sel` and `unlocked` unchanged.
- R3: In a digit-checking state, an edge with `entry_stb` high and `din` equal to the selected code digit advances the controller. The state steps through `digit_sel` 001 to 010 to 100, and after 100 it reaches the open state, where `unlocked` = 1 and `digit_sel` = 000.
- R4: In a digit-checking state, an edge with `entry_stb` high and `din` different from the selected digit moves the controller to the error state, where `digit_sel` = 000 and `unlocked` = 0.
- R5: In the open state, the outputs stay at `unlocked` = 1 and `digit_sel` = 000 whatever the strobe, data and write inputs are, until reset.
- R6: In the error state, the outputs stay at `unlocked` = 0 and `digit_sel` = 000 whatever the strobe, data and write inputs are, until reset.
- R7: Bit k of `code_wr` (bit 0 = digit 1, bit 1 = digit 2, bit 2 = digit 3) writes `din` into code digit k+1 on that edge. When several bits are high, every selected digit is written. A write alone never changes `digit_sel` or `unlocked`.
- R8: When an entry and a write to the selected digit fall on the same edge, the entry is judged against the digit stored before that edge. The newly written value applies only to later entries.
- R9: Reset overrides `entry_stb` and `code_wr` on the same edge. The state and the code both take their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 4 | Entered digit, and write data for the code registers |
| entry_stb | input | 1 | One-cycle strobe marking `din` as an entry |
| code_wr | input | 3 | Per-digit write enables for the code registers |
| unlocked | output | 1 | 1 only in the open state |
| digit_sel | output | 3 | One-hot selection of the expected code digit, 000 when terminal |

## Verification
Two functions can fall on the same edge: checking an entry and rewriting a code digit, sometimes the very digit being checked. The random stimulus raises `entry_stb` and `code_wr` independently and often feeds the expected digit, so the two coincide many times. Directed cases also rewrite the selected digit on the edge of a correct entry and of a wrong one. The bench judges each such edge against the pre-edge code held in its own model, and later entries confirm that the new digit was taken.

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl #(
  parameter int DW = 4,
  parameter logic [DW-1:0] DEF_D1 = 4'd3,
  parameter logic [DW-1:0] DEF_D2 = 4'd4,
  parameter logic [DW-1:0] DEF_D3 = 4'd2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          entry_stb,
  input  logic [2:0]    code_wr,
  output logic          unlocked,
  output logic [2:0]    digit_sel
);

  localparam int NDIG = 3;
  localparam logic [3:0] ST_D1   = 4'b0001;
  localparam logic [3:0] ST_D2   = 4'b0010;
  localparam logic [3:0] ST_D3   = 4'b0100;
  localparam logic [3:0] ST_OPEN = 4'b1000;
  localparam logic [3:0] ST_ERR  = 4'b0000;

  logic [3:0]    state, state_nx;
  logic [DW-1:0] code_q [NDIG];
  logic [DW-1:0] expect_d;
  logic          match;

  for (genvar k = 0; k < NDIG; k++) begin : g_code
    localparam logic [DW-1:0] DEF = (k == 0) ? DEF_D1 : (k == 1) ? DEF_D2 : DEF_D3;
    always_ff @(posedge clk) begin
      if (rst)             code_q[k] <= DEF;
      else if (code_wr[k]) code_q[k] <= din;
    end
  end

  always_comb begin
    expect_d = '0;
    for (int k = 0; k < NDIG; k++)
      if (state[k]) expect_d = expect_d | code_q[k];
  end

  assign match = (expect_d == din);

  always_comb begin
    state_nx = state;
    if (entry_stb) begin
      case (state)
        ST_D1:   state_nx = match ? ST_D2 : ST_ERR;
        ST_D2:   state_nx = match ? ST_D3 : ST_ERR;
        ST_D3:   state_nx = match ? ST_OPEN : ST_ERR;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_D1;
    else     state <= state_nx;
  end

  assign digit_sel = state[2:0];
  assign unlocked  = state[3];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_sel) && !(unlocked && digit_sel != 3'b000)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!entry_stb && digit_sel != 3'b000) |=> $stable(digit_sel) && !unlocked); // R2
  AST_BAD_DIGIT: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && digit_sel != 3'b000 && !match) |=> (digit_sel == 3'b000 && !unlocked)); // R4
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> (unlocked && digit_sel == 3'b000)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && digit_sel == 3'b000) |=> (!unlocked && digit_sel == 3'b000)); // R6
  AST_WR_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (code_wr != 3'b000 && !entry_stb) |=> ($stable(digit_sel) && $stable(unlocked))); // R7

endmodule

// File: tb/test_combo_lock_ctrl.sv
module test_combo_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] din;
  logic       entry_stb;
  logic [2:0] code_wr;
  logic       unlocked;
  logic [2:0] digit_sel;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_state;
  logic [3:0] m_code [3];

  always #10 clk = ~clk;

  combo_lock_ctrl i_combo_lock_ctrl (
    .clk(clk), .rst(rst), .din(din), .entry_stb(entry_stb),
    .code_wr(code_wr), .unlocked(unlocked), .digit_sel(digit_sel)
  );

  function automatic logic [3:0] digit_of(input logic [3:0] st);
    logic [3:0] d = 4'd0;
    for (int k = 0; k < 3; k++) if (st[k]) d = m_code[k];
    return d;
  endfunction

  function automatic logic [3:0] next_state(input logic [3:0] st, input logic stb,
                                            input logic [3:0] d);
    if (!stb || st == 4'b1000 || st == 4'b0000) return st;
    if (d != digit_of(st)) return 4'b0000;
    return {st[2:0], 1'b0};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (unlocked !== m_state[3] || digit_sel !== m_state[2:0]) begin
      errors++;
      $display("FAIL %s: unlocked=%0b digit_sel=%03b expected unlocked=%0b digit_sel=%03b",
               tag, unlocked, digit_sel, m_state[3], m_state[2:0]);
    end
  endtask

  task automatic step(input logic r, input logic stb, input logic [3:0] d, input logic [2:0] wr);
    string tag;
    @(negedge clk);
    rst = r; entry_stb = stb; din = d; code_wr = wr;
    if (r) tag = (stb || wr != 3'b000) ? "R9" : "R1";
    else if (m_state == 4'b1000) tag = "R5";
    else if (m_state == 4'b0000) tag = "R6";
    else if (!stb) tag = (wr != 3'b000) ? "R7" : "R2";
    else if ((wr & m_state[2:0]) != 3'b000) tag = "R8";
    else if (d == digit_of(m_state)) tag = "R3";
    else tag = "R4";
    if (r) begin
      m_state = 4'b0001;
      m_code[0] = 4'd3; m_code[1] = 4'd4; m_code[2] = 4'd2;
    end else begin
      m_state = next_state(m_state, stb, d);
      for (int k = 0; k < 3; k++) if (wr[k]) m_code[k] = d;
    end
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; entry_stb = 1'b0; din = 4'd0; code_wr = 3'b000;
    m_state = 4'b0001;
    m_code[0] = 4'd3; m_code[1] = 4'd4; m_code[2] = 4'd2;
    step(1, 0, 0, 3'b000);                               // R1
    step(0, 0, 4'd3, 3'b000);                            // R2
    step(0, 1, 4'd3, 3'b000);                            // R3
    step(0, 1, 4'd4, 3'b000);
    step(0, 1, 4'd2, 3'b000);                            // R3 open
    step(0, 1, 4'd9, 3'b111);                            // R5
    step(1, 0, 0, 3'b000);
    step(0, 1, 4'd3, 3'b000);
    step(0, 1, 4'd5, 3'b000);                            // R4
    step(0, 1, 4'd4, 3'b000);                            // R6
    step(1, 1, 4'd7, 3'b111);                            // R9
    step(0, 1, 4'd3, 3'b000);                            // defaults back after R9
    step(1, 0, 0, 3'b000);
    step(0, 0, 4'd6, 3'b011);                            // R7 multi-write
    step(0, 0, 4'd9, 3'b100);                            // R7
    step(0, 1, 4'd6, 3'b000);
    step(0, 1, 4'd6, 3'b000);
    step(0, 1, 4'd9, 3'b000);                            // opens with new code
    step(1, 0, 0, 3'b000);
    step(0, 1, 4'd3, 3'b001);                            // R8 old digit matches
    step(0, 1, 4'd8, 3'b010);                            // R8 new value not yet used -> err
    step(1, 0, 0, 3'b000);
    step(0, 0, 4'd1, 3'b010);
    step(0, 1, 4'd3, 3'b000);
    step(0, 1, 4'd1, 3'b000);                            // R8 rewritten digit now used
    for (int i = 0; i < 4000; i++) begin
      logic r, s;
      logic [3:0] d;
      logic [2:0] w;
      r = ($urandom_range(0, 39) == 0);
      s = ($urandom_range(0, 2) != 0);
      w = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      d = ($urandom_range(0, 4) != 0) ? digit_of(m_state) : 4'($urandom_range(0, 15));
      step(r, s, d, w);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule